// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Dormant Wakeup

This block receives asynchronous NRZ characters from a shared serial line. The line rests high. Each character opens with a low start bit, carries 8 or 9 data bits with the least significant bit first, and closes with a high stop bit. The line is oversampled by a tick enable running at `OVS` (default 16) times the bit rate. Each bit value is the majority vote of three samples taken around the middle of the bit. A completed character is placed in a holding register, and the receiver raises flags for data ready, overrun, noise, framing error, break and idle line.

On a multi-drop bus, a receiver that is not addressed by the current message can be put to sleep by setting its wakeup bit. While the bit is set, every status flag is held off, the idle flag included. The hardware clears the bit by itself through one of two methods, chosen by a select input. In idle-line mode the bit clears after one full frame time of continuous high line. In address-mark mode it clears on a character whose most significant data bit is 1, and that character is then delivered as normal data. Software may also set or clear the bit directly.

Top module: `urx_wakeup_rx`

## Requirements
- R1: With `nine_bit`=0, a start bit, eight data bits (LSB first) and a high stop bit load `rx_data[7:0]` with the byte, force `rx_data[8]` to 0 and set `data_rdy`.
- R2: With `nine_bit`=1, nine data bits are received LSB first into `rx_data[8:0]`.
- R3: Each bit is the majority of three samples at ticks OVS/2-1, OVS/2 and OVS/2+1 of the bit. A single disturbed sample leaves the data correct and sets `noise_flag` with that character.
- R4: A low pulse that reads high at the middle of the start bit is discarded as a false start and delivers no character.
- R5: A character whose stop bit samples low sets `frm_err` together with `data_rdy`.
- R6: A character that completes while `data_rdy` is still set raises `ovr_flag` and leaves `rx_data` holding the earlier character.
- R7: A frame of all-zero data whose stop bit also samples low is a break. It sets `brk_flag` and does not set `data_rdy` or `frm_err`.
- R8: `idle_flag` sets once the line has been high for a whole frame (10 bit times for 8-bit data, 11 for 9-bit data) after at least one character. A line that then stays high does not set it again.
- R9: While `wake_bit` is 1, none of `data_rdy`, `idle_flag`, `ovr_flag`, `noise_flag`, `frm_err` or `brk_flag` can become set.
- R10: With `wake_addr`=0, `wake_bit` clears by itself after one frame time of high line. That idle period does not set `idle_flag`, and characters sent back to back do not clear the bit.
- R11: With `wake_addr`=1, a character with its top data bit at 1 clears `wake_bit` and is delivered with `data_rdy`. A character whose top bit is 0 leaves the receiver dormant, and in this mode idle time does not clear the bit.
- R12: A `wake_set` pulse sets `wake_bit` and a `wake_clr` pulse clears it. An `rd_ack` pulse clears `data_rdy`, `ovr_flag`, `noise_flag`, `frm_err` and `brk_flag`. An `idle_ack` pulse clears `idle_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| rxd | input | 1 | Serial line, asynchronous |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| wake_set | input | 1 | Pulse that sets the wakeup bit |
| wake_clr | input | 1 | Pulse that clears the wakeup bit |
| rd_ack | input | 1 | Pulse that consumes the data and its error flags |
| idle_ack | input | 1 | Pulse that clears the idle flag |
| rx_data | output | DATA_W+1 | Received character |
| data_rdy | output | 1 | Character waiting |
| idle_flag | output | 1 | Idle line detected |
| ovr_flag | output | 1 | Overrun |
| noise_flag | output | 1 | Sample disagreement in the delivered character |
| frm_err | output | 1 | Stop bit read low |
| brk_flag | output | 1 | Break received |
| wake_bit | output | 1 | Receiver dormant |

## Verification
The hardest state to reach from the ports is a single disturbed sample inside the three-sample voting window. The bench drives `tick` on every clock and counts the two synchronizer stages and the detection edge. From that count it places a one-clock inversion exactly on the centre sample of a chosen data bit. Wakeup is also hard to observe, because the receiver shows nothing while dormant. The bench therefore sends whole messages while the receiver is asleep and reads the flags that stayed low. It then confirms the exact moment of wakeup through the next character that gets delivered.

// File: rtl/urx_pkg.sv
package urx_pkg;
   typedef enum logic [2:0] {
      ST_REST,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_WAIT_HI
   } urx_state_t;

   typedef struct packed {
      logic stop_ok;
      logic noisy;
      logic brk;
   } urx_fstat_t;
endpackage

// File: rtl/urx_bit_sampler.sv
module urx_bit_sampler #(
   parameter int OVS   = 16,
   parameter bit VOTE3 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rxd,
   input  logic run,
   output logic rxd_s,
   output logic bit_dec,
   output logic bit_val,
   output logic bit_noisy,
   output logic bit_end
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;
   localparam logic [CW-1:0] P_A   = CW'(MID - 1);
   localparam logic [CW-1:0] P_B   = CW'(MID);
   localparam logic [CW-1:0] P_C   = CW'(MID + 1);
   localparam logic [CW-1:0] P_END = CW'(OVS - 1);

   if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("urx_bit_sampler: OVS must be even and at least 8");
   end

   logic          sync1;
   logic [CW-1:0] cnt;
   logic          s_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1 <= 1'b1;
         rxd_s <= 1'b1;
      end else begin
         sync1 <= rxd;
         rxd_s <= sync1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (tick)       cnt <= (cnt == P_END) ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        s_b <= 1'b1;
      else if (run && tick && cnt == P_B) s_b <= rxd_s;
   end

   assign bit_dec = run && tick && (cnt == P_C);
   assign bit_end = run && tick && (cnt == P_END);

   if (VOTE3) begin : g_vote
      logic s_a;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        s_a <= 1'b1;
         else if (run && tick && cnt == P_A) s_a <= rxd_s;
      end
      assign bit_val   = (s_a & s_b) | (s_a & rxd_s) | (s_b & rxd_s);
      assign bit_noisy = !((s_a == s_b) && (s_b == rxd_s));
   end else begin : g_single
      assign bit_val   = s_b;
      assign bit_noisy = 1'b0;
   end

   // R3
   dec_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_dec |-> !bit_end);
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
   import urx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd_s,
   input  logic              nine_bit,
   input  logic              bit_dec,
   input  logic              bit_val,
   input  logic              bit_noisy,
   input  logic              bit_end,
   output logic              run,
   output logic              at_rest,
   output logic              fdone,
   output logic [DATA_W:0]   fdata,
   output logic              fnine,
   output urx_fstat_t        fstat
);
   localparam int IW = $clog2(DATA_W + 1);
   localparam logic [IW-1:0] LAST8 = IW'(DATA_W - 1);
   localparam logic [IW-1:0] LAST9 = IW'(DATA_W);

   if (DATA_W < 5) begin : g_bad_w
      $error("urx_frame_fsm: DATA_W too small");
   end

   urx_state_t      state;
   logic [IW-1:0]   idx;
   logic            noisy_acc;

   assign run     = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
   assign at_rest = (state == ST_REST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_REST;
         idx       <= '0;
         noisy_acc <= 1'b0;
         fdata     <= '0;
         fnine     <= 1'b0;
         fdone     <= 1'b0;
         fstat     <= '0;
      end else begin
         fdone <= 1'b0;
         unique case (state)
            ST_REST: if (tick && !rxd_s) begin
               state     <= ST_START;
               fdata     <= '0;
               fnine     <= nine_bit;
               noisy_acc <= 1'b0;
               idx       <= '0;
            end
            ST_START: begin
               if (bit_dec) begin
                  if (bit_val) state <= ST_REST;
                  noisy_acc <= bit_noisy;
               end
               if (bit_end) state <= ST_DATA;
            end
            ST_DATA: begin
               if (bit_dec) begin
                  fdata[idx] <= bit_val;
                  noisy_acc  <= noisy_acc | bit_noisy;
               end
               if (bit_end) begin
                  if (idx == (fnine ? LAST9 : LAST8)) state <= ST_STOP;
                  idx <= idx + 1'b1;
               end
            end
            ST_STOP: if (bit_dec) begin
               fdone         <= 1'b1;
               fstat.stop_ok <= bit_val;
               fstat.noisy   <= noisy_acc | bit_noisy;
               fstat.brk     <= !bit_val && (fdata == '0);
               state         <= bit_val ? ST_REST : ST_WAIT_HI;
            end
            ST_WAIT_HI: if (rxd_s) state <= ST_REST;
            default: state <= ST_REST;
         endcase
      end
   end

   // R1
   eight_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fdone && !fnine) |-> (fdata[DATA_W] == 1'b0));

   // R7
   brk_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fdone && fstat.brk) |-> !fstat.stop_ok);
endmodule

// File: rtl/urx_idle_det.sv
module urx_idle_det #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line_hi,
   input  logic nine_bit,
   output logic idle_ev
);
   localparam int CW = $clog2((DATA_W + 3) * OVS + 1);
   localparam logic [CW-1:0] THR8 = CW'((DATA_W + 2) * OVS);
   localparam logic [CW-1:0] THR9 = CW'((DATA_W + 3) * OVS);

   logic [CW-1:0] cnt;
   logic [CW-1:0] thr;

   assign thr = nine_bit ? THR9 : THR8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         idle_ev <= 1'b0;
      end else begin
         idle_ev <= line_hi && tick && (cnt == thr - 1'b1);
         if (!line_hi)             cnt <= '0;
         else if (tick && cnt < thr) cnt <= cnt + 1'b1;
      end
   end

   // R8
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_ev |=> !idle_ev);
endmodule

// File: rtl/urx_wakeup_rx.sv
module urx_wakeup_rx
   import urx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter bit VOTE3  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            rxd,
   input  logic            nine_bit,
   input  logic            wake_addr,
   input  logic            wake_set,
   input  logic            wake_clr,
   input  logic            rd_ack,
   input  logic            idle_ack,
   output logic [DATA_W:0] rx_data,
   output logic            data_rdy,
   output logic            idle_flag,
   output logic            ovr_flag,
   output logic            noise_flag,
   output logic            frm_err,
   output logic            brk_flag,
   output logic            wake_bit
);
   logic            rxd_s, bit_dec, bit_val, bit_noisy, bit_end;
   logic            run, at_rest, fdone, fnine, idle_ev, armed;
   logic [DATA_W:0] fdata;
   urx_fstat_t      fstat;
   logic            top_bit, addr_hit, dormant;

   urx_bit_sampler #(.OVS(OVS), .VOTE3(VOTE3)) u_smp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .run(run),
      .rxd_s(rxd_s), .bit_dec(bit_dec), .bit_val(bit_val),
      .bit_noisy(bit_noisy), .bit_end(bit_end)
   );

   urx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s),
      .nine_bit(nine_bit), .bit_dec(bit_dec), .bit_val(bit_val),
      .bit_noisy(bit_noisy), .bit_end(bit_end), .run(run),
      .at_rest(at_rest), .fdone(fdone), .fdata(fdata), .fnine(fnine),
      .fstat(fstat)
   );

   urx_idle_det #(.DATA_W(DATA_W), .OVS(OVS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_hi(at_rest && rxd_s),
      .nine_bit(nine_bit), .idle_ev(idle_ev)
   );

   assign top_bit  = fnine ? fdata[DATA_W] : fdata[DATA_W-1];
   assign addr_hit = fdone && wake_bit && wake_addr && top_bit && !fstat.brk;
   assign dormant  = wake_bit && !addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wake_bit <= 1'b0;
      else if (wake_set)                 wake_bit <= 1'b1;
      else if (wake_clr)                 wake_bit <= 1'b0;
      else if (addr_hit)                 wake_bit <= 1'b0;
      else if (idle_ev && !wake_addr)    wake_bit <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         data_rdy   <= 1'b0;
         ovr_flag   <= 1'b0;
         noise_flag <= 1'b0;
         frm_err    <= 1'b0;
         brk_flag   <= 1'b0;
      end else begin
         if (rd_ack) begin
            data_rdy   <= 1'b0;
            ovr_flag   <= 1'b0;
            noise_flag <= 1'b0;
            frm_err    <= 1'b0;
            brk_flag   <= 1'b0;
         end
         if (fdone && !dormant) begin
            if (fstat.brk) begin
               brk_flag <= 1'b1;
            end else if (data_rdy && !rd_ack) begin
               ovr_flag <= 1'b1;
            end else begin
               rx_data    <= fdata;
               data_rdy   <= 1'b1;
               noise_flag <= fstat.noisy;
               frm_err    <= !fstat.stop_ok;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         idle_flag <= 1'b0;
      end else begin
         if (fdone)        armed <= 1'b1;
         else if (idle_ev) armed <= 1'b0;
         if (idle_ack)     idle_flag <= 1'b0;
         if (idle_ev && armed && !wake_bit) idle_flag <= 1'b1;
      end
   end

   // R9
   dormant_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_rdy) |-> (!$past(wake_bit) || !wake_bit));

   // R9
   dormant_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err) |-> (!$past(wake_bit) || !wake_bit));

   // R9
   dormant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_flag) |-> !$past(wake_bit));

   // R6
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> ($stable(rx_data) && data_rdy));

   // R7
   brk_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> !$rose(data_rdy));

   // R10
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wake_bit) && !$past(wake_clr) && !$past(wake_addr)) |-> $past(idle_ev));
endmodule

// File: tb/tb_urx_wakeup_rx.sv
module tb_urx_wakeup_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       rxd = 1'b1;
   logic       nine_bit = 1'b0;
   logic       wake_addr = 1'b0;
   logic       wake_set = 1'b0;
   logic       wake_clr = 1'b0;
   logic       rd_ack = 1'b0;
   logic       idle_ack = 1'b0;
   logic [8:0] rx_data;
   logic       data_rdy, idle_flag, ovr_flag, noise_flag, frm_err, brk_flag, wake_bit;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   urx_wakeup_rx dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit(nine_bit),
      .wake_addr(wake_addr), .wake_set(wake_set), .wake_clr(wake_clr),
      .rd_ack(rd_ack), .idle_ack(idle_ack), .rx_data(rx_data),
      .data_rdy(data_rdy), .idle_flag(idle_flag), .ovr_flag(ovr_flag),
      .noise_flag(noise_flag), .frm_err(frm_err), .brk_flag(brk_flag),
      .wake_bit(wake_bit)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle_cycles(input int n);
      rxd = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_bit(input logic v, input bit glitch);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         rxd = (glitch && k == 9) ? ~v : v;
      end
   endtask

   // glitch_at: 0 start, 1..n data bits, n+1 stop; -1 none
   task automatic send_frame(input logic [8:0] d, input bit nine, input logic stop, input int glitch_at);
      int nb;
      nb = nine ? 9 : 8;
      drive_bit(1'b0, glitch_at == 0);
      for (int i = 0; i < nb; i++) drive_bit(d[i], glitch_at == i + 1);
      drive_bit(stop, glitch_at == nb + 1);
      @(negedge clk);
      rxd = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
   endtask

   task automatic pulse_idle_ack();
      @(negedge clk); idle_ack = 1'b1;
      @(negedge clk); idle_ack = 1'b0;
   endtask

   task automatic settle();
      idle_cycles(400);
      pulse_rd();
      pulse_idle_ack();
   endtask

   task automatic t_reset();
      check("R12 reset data_rdy", data_rdy, 0);
      check("R12 reset idle_flag", idle_flag, 0);
      check("R12 reset err flags", {ovr_flag, noise_flag, frm_err, brk_flag}, 0);
      check("R12 reset wake_bit", wake_bit, 0);
      check("R12 reset rx_data", rx_data, 0);
   endtask

   task automatic t_basic8();
      settle();
      send_frame(9'h0A5, 1'b0, 1'b1, -1);
      check("R1 data_rdy", data_rdy, 1);
      check("R1 rx_data", rx_data, 9'h0A5);
      check("R1 no errors", {ovr_flag, noise_flag, frm_err, brk_flag}, 0);
      pulse_rd();
      check("R12 rd_ack clears data_rdy", data_rdy, 0);
   endtask

   task automatic t_nine();
      settle();
      nine_bit = 1'b1;
      send_frame(9'h1C3, 1'b1, 1'b1, -1);
      check("R2 data_rdy", data_rdy, 1);
      check("R2 rx_data", rx_data, 9'h1C3);
      nine_bit = 1'b0;
      pulse_rd();
   endtask

   task automatic t_noise();
      settle();
      send_frame(9'h00F, 1'b0, 1'b1, 4);
      check("R3 data despite glitch", rx_data, 9'h00F);
      check("R3 noise_flag", noise_flag, 1);
      pulse_rd();
      check("R12 rd_ack clears noise", noise_flag, 0);
   endtask

   task automatic t_false_start();
      settle();
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      idle_cycles(200);
      check("R4 false start no data", data_rdy, 0);
      check("R4 false start no flags", {frm_err, brk_flag}, 0);
   endtask

   task automatic t_frame_err();
      settle();
      send_frame(9'h055, 1'b0, 1'b0, -1);
      check("R5 frm_err", frm_err, 1);
      check("R5 data_rdy", data_rdy, 1);
      check("R5 rx_data", rx_data, 9'h055);
      check("R5 not break", brk_flag, 0);
      pulse_rd();
      check("R12 rd_ack clears frm_err", frm_err, 0);
   endtask

   task automatic t_overrun();
      settle();
      send_frame(9'h03C, 1'b0, 1'b1, -1);
      send_frame(9'h0C3, 1'b0, 1'b1, -1);
      check("R6 ovr_flag", ovr_flag, 1);
      check("R6 earlier data kept", rx_data, 9'h03C);
      pulse_rd();
      check("R12 rd_ack clears ovr", ovr_flag, 0);
   endtask

   task automatic t_break();
      settle();
      @(negedge clk); rxd = 1'b0;
      repeat (12 * 16) @(negedge clk);
      check("R7 brk_flag", brk_flag, 1);
      check("R7 no data_rdy", data_rdy, 0);
      check("R7 no frm_err", frm_err, 0);
      idle_cycles(20);
      pulse_rd();
      check("R12 rd_ack clears brk", brk_flag, 0);
   endtask

   task automatic t_idle();
      settle();
      send_frame(9'h05A, 1'b0, 1'b1, -1);
      idle_cycles(100);
      check("R8 not idle before frame time", idle_flag, 0);
      idle_cycles(100);
      check("R8 idle after frame time", idle_flag, 1);
      pulse_idle_ack();
      check("R12 idle_ack clears", idle_flag, 0);
      idle_cycles(400);
      check("R8 no repeat without character", idle_flag, 0);
      pulse_rd();
   endtask

   task automatic t_wake_idle();
      settle();
      wake_addr = 1'b0;
      @(negedge clk); wake_set = 1'b1;
      @(negedge clk); wake_set = 1'b0;
      check("R12 wake_set", wake_bit, 1);
      send_frame(9'h022, 1'b0, 1'b1, -1);
      check("R9 dormant no data_rdy", data_rdy, 0);
      check("R10 back-to-back keeps dormant", wake_bit, 1);
      send_frame(9'h033, 1'b0, 1'b1, -1);
      check("R10 still dormant", wake_bit, 1);
      idle_cycles(200);
      check("R10 idle clears wake", wake_bit, 0);
      check("R10 no idle_flag on wake", idle_flag, 0);
      check("R9 nothing delivered", data_rdy, 0);
      send_frame(9'h044, 1'b0, 1'b1, -1);
      check("R10 awake delivers", rx_data, 9'h044);
      check("R10 awake data_rdy", data_rdy, 1);
      pulse_rd();
   endtask

   task automatic t_wake_addr();
      settle();
      wake_addr = 1'b1;
      @(negedge clk); wake_set = 1'b1;
      @(negedge clk); wake_set = 1'b0;
      send_frame(9'h012, 1'b0, 1'b0, -1);
      check("R9 dormant no frm_err", frm_err, 0);
      check("R9 dormant no data_rdy", data_rdy, 0);
      check("R11 top bit 0 stays dormant", wake_bit, 1);
      idle_cycles(250);
      check("R11 idle does not wake", wake_bit, 1);
      check("R9 dormant no idle_flag", idle_flag, 0);
      send_frame(9'h085, 1'b0, 1'b1, -1);
      check("R11 address wakes", wake_bit, 0);
      check("R11 address delivered", data_rdy, 1);
      check("R11 address data", rx_data, 9'h085);
      pulse_rd();
      wake_addr = 1'b0;
   endtask

   task automatic t_sw_clear();
      settle();
      @(negedge clk); wake_set = 1'b1;
      @(negedge clk); wake_set = 1'b0;
      check("R12 set before clear", wake_bit, 1);
      @(negedge clk); wake_clr = 1'b1;
      @(negedge clk); wake_clr = 1'b0;
      check("R12 wake_clr", wake_bit, 0);
      send_frame(9'h099, 1'b0, 1'b1, -1);
      check("R12 awake after clear", rx_data, 9'h099);
      pulse_rd();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic8();
      t_nine();
      t_noise();
      t_false_start();
      t_frame_err();
      t_overrun();
      t_break();
      t_idle();
      t_wake_idle();
      t_wake_addr();
      t_sw_clear();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule